// File: doc/BRIEF.md
# Nonvolatile wiper store/restore sequencer

This block owns the 6-bit position code of a 64-step digital potentiometer and a single nonvolatile backing cell for that code. After power-on reset the position is forced to midscale (code 0x20) for a short preset window. An automatic boot load then copies the backing cell into the position register. If the cell has never been programmed, the position stays at midscale. After boot the block carries out already-decoded command strobes from a serial front end: set position, program the cell, save the position into the cell, recall the cell into the position, set or clear a software write guard, and no-operation.

Slow nonvolatile operations run inside timed busy windows whose lengths are parameters counted in timebase ticks (`tick_i`), so a fast test can shorten them. The write guard blocks only the commands that would change the backing cell. A direct position write is still honoured while the guard is set. Long operations and guarded operations that cannot be accepted are dropped, and a one-cycle `reject_o` pulse reports the drop. The backing cell is modelled as a register with a programmed flag; its factory-blank state is set by `blank_ni`.

The controller has five states:
- `ST_PRESET`: midscale hold after reset.
- `ST_BOOT_LOAD`: automatic recall window.
- `ST_IDLE`: waiting for commands.
- `ST_NVPROG`: timed cell programming, used for both save and program-cell.
- `ST_RECALL`: timed recall on command.

The transitions are:
- PRESET→BOOT_LOAD when the preset window expires.
- BOOT_LOAD→IDLE when the boot window expires; the cell is loaded into the position.
- IDLE→NVPROG on an accepted save or program-cell command.
- IDLE→RECALL on an accepted recall command.
- NVPROG→IDLE when the window expires; the pending value is committed to the cell.
- RECALL→IDLE when the window expires; the cell is loaded into the position.

Top module: `wiper_nv_seq`

## Requirements
- R1: While reset is held, and for exactly `PRESET_CYC` ticks after its release, `wiper_o` is 0x20 and `busy_o` is 1.
- R2: The boot window lasts `BOOT_CYC` ticks after the preset window. At its end `wiper_o` takes the cell value and `busy_o` falls, so `busy_o` stays high for `PRESET_CYC+BOOT_CYC` cycles after release when ticking every cycle.
- R3: Opcode 3'b000 (set position) loads `cmd_data_i[5:0]` into `wiper_o` on the next clock edge, with no busy window.
- R4: Opcode 3'b110 (save) keeps `busy_o` high for `PROG_CYC` ticks. It then writes to the cell the position value held when the command was accepted; `rd_nv_o` does not change before the window ends.
- R5: Opcode 3'b101 (recall) keeps `busy_o` high for `RECALL_CYC` ticks, then `wiper_o` equals the cell value.
- R6: Opcode 3'b001 (program cell) keeps `busy_o` high for `PROG_CYC` ticks, then `rd_nv_o` equals `cmd_data_i[5:0]`.
- R7: Opcode 3'b010 sets the write guard to `cmd_data_i[0]`. While the guard is 1, save and program-cell are rejected: `reject_o` pulses, `busy_o` stays 0 and the cell is unchanged.
- R8: Set position (3'b000) is accepted while the write guard is 1.
- R9: Opcodes 3'b100, 3'b011 and 3'b111 are no-operations: no output changes and no `reject_o`.
- R10: A save, recall or program-cell command arriving while `busy_o` is 1 is rejected with a one-cycle `reject_o` pulse. The running window keeps its length and its result. A set-position command during a recall window is also rejected.
- R11: An unprogrammed cell reads back as 0x20 on `rd_nv_o`, and a recall from it yields 0x20.
- R12: Window counters advance only in cycles where `tick_i` is 1.
- R13: Any command other than a no-operation that arrives during the preset or boot window is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset of the sequencer |
| blank_ni | input | 1 | Active-low reset of the modelled cell to its unprogrammed state |
| tick_i | input | 1 | Timebase strobe; window counters advance when 1 |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 3 | Command opcode |
| cmd_data_i | input | WIPER_W | Command data (position, cell value or guard bit in bit 0) |
| wiper_o | output | WIPER_W | Current position code |
| rd_nv_o | output | WIPER_W | Readback of the cell (0x20 when unprogrammed) |
| busy_o | output | 1 | High during preset, boot, programming and recall windows |
| reject_o | output | 1 | One-cycle pulse the cycle after a dropped command |

## Verification
A wrong state shows up on `busy_o` first: a window that ends early or late changes the busy length by at least one cycle. The bench measures every window exactly. A wrong pending or cell value shows up on `rd_nv_o` or `wiper_o` in the first cycle after the window closes. A lost guard or busy interlock shows up as a missing `reject_o` pulse one cycle after the command, or as an unexpected busy window. Boot behaviour is checked after a blank start and after a warm reset with a programmed cell, so that a missing preset or a missing boot load changes `wiper_o` right at reset release or at the end of the boot window.

// File: rtl/wnv_pkg.sv
`timescale 1ns/1ps
package wnv_pkg;

    typedef enum logic [2:0] {
        OP_WR_WIPER = 3'b000,
        OP_WR_NV    = 3'b001,
        OP_PROTECT  = 3'b010,
        OP_NOP      = 3'b100,
        OP_RECALL   = 3'b101,
        OP_SAVE     = 3'b110
    } wnv_op_e;

    typedef enum logic [2:0] {
        ST_PRESET,
        ST_BOOT_LOAD,
        ST_IDLE,
        ST_NVPROG,
        ST_RECALL
    } wnv_state_e;

    // Opcodes that do something; everything else behaves as a no-operation.
    function automatic logic op_is_active(input logic [2:0] op);
        return (op == OP_WR_WIPER) || (op == OP_WR_NV) || (op == OP_PROTECT) ||
               (op == OP_RECALL)   || (op == OP_SAVE);
    endfunction

endpackage

// File: rtl/wnv_timer.sv
`timescale 1ns/1ps
module wnv_timer #(
    parameter int CNT_W   = 6,
    parameter int RST_LEN = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    // Loaded with len-1 so that a window of len ticks expires on its last tick.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= CNT_W'(RST_LEN - 1);
        end else if (load_i) begin
            cnt_q <= len_i - CNT_W'(1);
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expire_o = tick_i && (cnt_q == '0);

endmodule

// File: rtl/wnv_cell.sv
`timescale 1ns/1ps
module wnv_cell #(
    parameter int W = 6
) (
    input  logic         clk_i,
    input  logic         blank_ni,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rdata_o
);
    localparam logic [W-1:0] MID = W'(1) << (W - 1);

    logic         prog_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk_i or negedge blank_ni) begin
        if (!blank_ni) begin
            prog_q <= 1'b0;
            data_q <= MID;
        end else if (we_i) begin
            prog_q <= 1'b1;
            data_q <= wdata_i;
        end
    end

    // A blank cell reads as midscale.
    assign rdata_o = prog_q ? data_q : MID;

endmodule

// File: rtl/wnv_fsm.sv
`timescale 1ns/1ps
module wnv_fsm
    import wnv_pkg::*;
#(
    parameter int W          = 6,
    parameter int CNT_W      = 6,
    parameter int BOOT_CYC   = 20,
    parameter int RECALL_CYC = 12,
    parameter int PROG_CYC   = 40
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cmd_valid_i,
    input  logic [2:0]       cmd_op_i,
    input  logic [W-1:0]     cmd_data_i,
    input  logic             expire_i,
    input  logic [W-1:0]     nv_rdata_i,
    output wnv_state_e       state_o,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_len_o,
    output logic             nv_we_o,
    output logic [W-1:0]     nv_wdata_o,
    output logic [W-1:0]     wiper_o,
    output logic             reject_o,
    output logic             prot_o,
    output logic             busy_o
);
    localparam logic [W-1:0] MID = W'(1) << (W - 1);

    wnv_state_e   state_q, state_d;
    logic [W-1:0] wiper_q, pend_q;
    logic         prot_q, reject_q;

    logic booting, in_idle;
    logic op_changes_nv, op_long;
    logic acc_long, acc_wiper, acc_prot, reject_d;
    logic take_nv;

    // Command acceptance.
    always_comb begin
        booting       = (state_q == ST_PRESET) || (state_q == ST_BOOT_LOAD);
        in_idle       = (state_q == ST_IDLE);
        op_changes_nv = (cmd_op_i == OP_SAVE) || (cmd_op_i == OP_WR_NV);
        op_long       = op_changes_nv || (cmd_op_i == OP_RECALL);
        acc_long      = cmd_valid_i && in_idle && op_long && !(op_changes_nv && prot_q);
        acc_wiper     = cmd_valid_i && (cmd_op_i == OP_WR_WIPER) && !booting &&
                        (state_q != ST_RECALL);
        acc_prot      = cmd_valid_i && (cmd_op_i == OP_PROTECT) && !booting;
        reject_d      = cmd_valid_i && op_is_active(cmd_op_i) &&
                        (booting || (op_long && !acc_long) ||
                         ((cmd_op_i == OP_WR_WIPER) && (state_q == ST_RECALL)));
    end

    // Next state and control.
    always_comb begin
        state_d    = state_q;
        tmr_load_o = 1'b0;
        tmr_len_o  = CNT_W'(PROG_CYC);
        nv_we_o    = 1'b0;
        take_nv    = 1'b0;
        unique case (state_q)
            ST_PRESET: begin
                if (expire_i) begin
                    state_d    = ST_BOOT_LOAD;
                    tmr_load_o = 1'b1;
                    tmr_len_o  = CNT_W'(BOOT_CYC);
                end
            end
            ST_BOOT_LOAD: begin
                if (expire_i) begin
                    state_d = ST_IDLE;
                    take_nv = 1'b1;
                end
            end
            ST_IDLE: begin
                if (acc_long) begin
                    tmr_load_o = 1'b1;
                    if (cmd_op_i == OP_RECALL) begin
                        state_d   = ST_RECALL;
                        tmr_len_o = CNT_W'(RECALL_CYC);
                    end else begin
                        state_d   = ST_NVPROG;
                        tmr_len_o = CNT_W'(PROG_CYC);
                    end
                end
            end
            ST_NVPROG: begin
                if (expire_i) begin
                    state_d = ST_IDLE;
                    nv_we_o = 1'b1;
                end
            end
            ST_RECALL: begin
                if (expire_i) begin
                    state_d = ST_IDLE;
                    take_nv = 1'b1;
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_PRESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Output and data registers.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wiper_q  <= MID;
            pend_q   <= MID;
            prot_q   <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            reject_q <= reject_d;
            if (take_nv) begin
                wiper_q <= nv_rdata_i;
            end else if (acc_wiper) begin
                wiper_q <= cmd_data_i;
            end
            if (acc_prot) begin
                prot_q <= cmd_data_i[0];
            end
            if (acc_long && op_changes_nv) begin
                pend_q <= (cmd_op_i == OP_SAVE) ? wiper_q : cmd_data_i;
            end
        end
    end

    assign state_o    = state_q;
    assign nv_wdata_o = pend_q;
    assign wiper_o    = wiper_q;
    assign reject_o   = reject_q;
    assign prot_o     = prot_q;
    assign busy_o     = (state_q != ST_IDLE);

endmodule

// File: rtl/wiper_nv_seq.sv
`timescale 1ns/1ps
module wiper_nv_seq
    import wnv_pkg::*;
#(
    parameter int WIPER_W    = 6,
    parameter int PRESET_CYC = 4,
    parameter int BOOT_CYC   = 20,
    parameter int RECALL_CYC = 12,
    parameter int PROG_CYC   = 40
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               blank_ni,
    input  logic               tick_i,
    input  logic               cmd_valid_i,
    input  logic [2:0]         cmd_op_i,
    input  logic [WIPER_W-1:0] cmd_data_i,
    output logic [WIPER_W-1:0] wiper_o,
    output logic [WIPER_W-1:0] rd_nv_o,
    output logic               busy_o,
    output logic               reject_o
);
    localparam int MAX_A   = (PRESET_CYC > BOOT_CYC) ? PRESET_CYC : BOOT_CYC;
    localparam int MAX_B   = (RECALL_CYC > PROG_CYC) ? RECALL_CYC : PROG_CYC;
    localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    wnv_state_e         fsm_state;
    logic               fsm_prot;
    logic               tmr_expire, tmr_load;
    logic [CNT_W-1:0]   tmr_len;
    logic               nv_we;
    logic [WIPER_W-1:0] nv_wdata, nv_rdata;

    wnv_timer #(.CNT_W(CNT_W), .RST_LEN(PRESET_CYC)) timer_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .load_i   (tmr_load),
        .len_i    (tmr_len),
        .expire_o (tmr_expire)
    );

    wnv_cell #(.W(WIPER_W)) cell_i (
        .clk_i    (clk_i),
        .blank_ni (blank_ni),
        .we_i     (nv_we),
        .wdata_i  (nv_wdata),
        .rdata_o  (nv_rdata)
    );

    wnv_fsm #(
        .W(WIPER_W), .CNT_W(CNT_W), .BOOT_CYC(BOOT_CYC),
        .RECALL_CYC(RECALL_CYC), .PROG_CYC(PROG_CYC)
    ) fsm_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cmd_valid_i (cmd_valid_i),
        .cmd_op_i    (cmd_op_i),
        .cmd_data_i  (cmd_data_i),
        .expire_i    (tmr_expire),
        .nv_rdata_i  (nv_rdata),
        .state_o     (fsm_state),
        .tmr_load_o  (tmr_load),
        .tmr_len_o   (tmr_len),
        .nv_we_o     (nv_we),
        .nv_wdata_o  (nv_wdata),
        .wiper_o     (wiper_o),
        .reject_o    (reject_o),
        .prot_o      (fsm_prot),
        .busy_o      (busy_o)
    );

    assign rd_nv_o = nv_rdata;

endmodule

// File: rtl/wnv_checker.sv
`timescale 1ns/1ps
module wnv_checker
    import wnv_pkg::*;
#(
    parameter int W = 6
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         blank_ni,
    input logic         tick_i,
    input logic         cmd_valid_i,
    input logic [2:0]   cmd_op_i,
    input logic [W-1:0] cmd_data_i,
    input logic [W-1:0] wiper_o,
    input logic [W-1:0] rd_nv_o,
    input logic         busy_o,
    input logic         reject_o,
    input wnv_state_e   state_i,
    input logic         prot_i,
    input logic         expire_i
);
    localparam logic [W-1:0] MID = W'(1) << (W - 1);

    AST_PRESET_MIDSCALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_PRESET) |-> (wiper_o == MID && busy_o)); // R1

    AST_SET_POSITION: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_op_i == OP_WR_WIPER && state_i == ST_IDLE)
        |=> (wiper_o == $past(cmd_data_i))); // R3

    AST_CELL_CHANGES_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni || !blank_ni)
        !$stable(rd_nv_o) |-> $past(busy_o)); // R4

    AST_GUARD_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prot_i && cmd_valid_i && cmd_op_i == OP_WR_NV && state_i == ST_IDLE)
        |=> (reject_o && !busy_o)); // R7

    AST_NOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_op_i == OP_NOP && state_i == ST_IDLE)
        |=> ($stable(wiper_o) && !reject_o && !busy_o)); // R9

    AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_op_i == OP_RECALL && state_i == ST_NVPROG && !expire_i)
        |=> (reject_o && state_i == ST_NVPROG)); // R10

    AST_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && busy_o) |=> busy_o); // R12

    AST_BOOT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_op_i == OP_SAVE &&
         (state_i == ST_PRESET || state_i == ST_BOOT_LOAD)) |=> reject_o); // R13

endmodule

bind wiper_nv_seq wnv_checker #(.W(WIPER_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .blank_ni    (blank_ni),
    .tick_i      (tick_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_data_i  (cmd_data_i),
    .wiper_o     (wiper_o),
    .rd_nv_o     (rd_nv_o),
    .busy_o      (busy_o),
    .reject_o    (reject_o),
    .state_i     (fsm_state),
    .prot_i      (fsm_prot),
    .expire_i    (tmr_expire)
);

// File: tb/wiper_nv_seq_tb_top.sv
`timescale 1ns/1ps
module wiper_nv_seq_tb_top;

    localparam int T_PRESET = 4;
    localparam int T_BOOT   = 20;
    localparam int T_RECALL = 12;
    localparam int T_PROG   = 40;

    localparam logic [2:0] C_WRW  = 3'b000;
    localparam logic [2:0] C_WRNV = 3'b001;
    localparam logic [2:0] C_PROT = 3'b010;
    localparam logic [2:0] C_NOP  = 3'b100;
    localparam logic [2:0] C_REC  = 3'b101;
    localparam logic [2:0] C_SAVE = 3'b110;

    typedef struct packed {
        logic [2:0] op;
        logic [5:0] data;
        logic [5:0] exp_w;
        logic [5:0] exp_nv;
        logic       exp_rej;
        logic [7:0] exp_len;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{C_WRW,  6'h05, 6'h05, 6'h20, 1'b0, 8'd0},        // R3
        '{C_SAVE, 6'h00, 6'h05, 6'h05, 1'b0, 8'(T_PROG)},  // R4
        '{C_WRW,  6'h3F, 6'h3F, 6'h05, 1'b0, 8'd0},        // R3
        '{C_REC,  6'h00, 6'h05, 6'h05, 1'b0, 8'(T_RECALL)},// R5
        '{C_WRNV, 6'h2A, 6'h05, 6'h2A, 1'b0, 8'(T_PROG)},  // R6
        '{C_PROT, 6'h01, 6'h05, 6'h2A, 1'b0, 8'd0},        // R7
        '{C_WRNV, 6'h11, 6'h05, 6'h2A, 1'b1, 8'd0},        // R7
        '{C_SAVE, 6'h00, 6'h05, 6'h2A, 1'b1, 8'd0},        // R7
        '{C_WRW,  6'h00, 6'h00, 6'h2A, 1'b0, 8'd0},        // R8
        '{C_NOP,  6'h3F, 6'h00, 6'h2A, 1'b0, 8'd0},        // R9
        '{3'b011, 6'h3F, 6'h00, 6'h2A, 1'b0, 8'd0},        // R9
        '{3'b111, 6'h3F, 6'h00, 6'h2A, 1'b0, 8'd0},        // R9
        '{C_PROT, 6'h00, 6'h00, 6'h2A, 1'b0, 8'd0},        // R7
        '{C_WRW,  6'h15, 6'h15, 6'h2A, 1'b0, 8'd0},        // R3
        '{C_SAVE, 6'h00, 6'h15, 6'h15, 1'b0, 8'(T_PROG)},  // R4
        '{C_WRW,  6'h3F, 6'h3F, 6'h15, 1'b0, 8'd0},        // R3
        '{C_REC,  6'h00, 6'h15, 6'h15, 1'b0, 8'(T_RECALL)} // R5
    };

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       blank_ni = 1'b0;
    logic       tick_i = 1'b1;
    logic       tick_slow = 1'b0;
    logic       cmd_valid_i = 1'b0;
    logic [2:0] cmd_op_i = 3'b100;
    logic [5:0] cmd_data_i = '0;
    logic [5:0] wiper_o, rd_nv_o;
    logic       busy_o, reject_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    always @(negedge clk) tick_i <= tick_slow ? ~tick_i : 1'b1;

    wiper_nv_seq #(
        .WIPER_W(6), .PRESET_CYC(T_PRESET), .BOOT_CYC(T_BOOT),
        .RECALL_CYC(T_RECALL), .PROG_CYC(T_PROG)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .blank_ni(blank_ni), .tick_i(tick_i),
        .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_data_i(cmd_data_i),
        .wiper_o(wiper_o), .rd_nv_o(rd_nv_o), .busy_o(busy_o), .reject_o(reject_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Starts and ends at a falling edge; the sample after it shows reject_o.
    task automatic do_cmd(input logic [2:0] op, input logic [5:0] data);
        cmd_valid_i = 1'b1;
        cmd_op_i    = op;
        cmd_data_i  = data;
        @(posedge clk);
        @(negedge clk);
        cmd_valid_i = 1'b0;
        cmd_op_i    = C_NOP;
    endtask

    task automatic wait_idle(output int len);
        len = 0;
        while (busy_o && len < 1000) begin
            len++;
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            C_WRW:   return "R3";
            C_WRNV:  return "R6";
            C_SAVE:  return "R4";
            C_REC:   return "R5";
            C_PROT:  return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int len;
        // Blank power-up.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "wiper in reset", wiper_o, 6'h20);
        chk("R1", "busy in reset", busy_o, 1);
        rst_ni = 1'b1;
        blank_ni = 1'b1;
        chk("R1", "wiper at release", wiper_o, 6'h20);
        wait_idle(len);
        chk("R2", "boot busy length", len, T_PRESET + T_BOOT);
        chk("R11", "blank boot wiper", wiper_o, 6'h20);
        chk("R11", "blank cell readback", rd_nv_o, 6'h20);
        chk("R1", "reject idle", reject_o, 0);

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            do_cmd(VECS[i].op, VECS[i].data);
            chk(tag_of(VECS[i].op), $sformatf("v%0d reject", i), reject_o, VECS[i].exp_rej);
            wait_idle(len);
            chk(VECS[i].exp_rej ? "R7" : tag_of(VECS[i].op),
                $sformatf("v%0d busy length", i), len, VECS[i].exp_len);
            chk(tag_of(VECS[i].op), $sformatf("v%0d wiper", i), wiper_o, VECS[i].exp_w);
            chk(tag_of(VECS[i].op), $sformatf("v%0d cell", i), rd_nv_o, VECS[i].exp_nv);
        end

        // Warm reset with a programmed cell (0x15).
        rst_ni = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_ni = 1'b1;
        chk("R1", "warm preset wiper", wiper_o, 6'h20);
        do_cmd(C_SAVE, 6'h00);
        chk("R13", "save during preset rejected", reject_o, 1);
        chk("R1", "preset wiper held", wiper_o, 6'h20);
        wait_idle(len);
        chk("R2", "warm boot length", len + 1, T_PRESET + T_BOOT);
        chk("R2", "warm boot wiper", wiper_o, 6'h15);
        chk("R13", "cell untouched by boot command", rd_nv_o, 6'h15);

        // Busy interlock and capture at command time.
        do_cmd(C_WRW, 6'h09);
        do_cmd(C_SAVE, 6'h00);
        do_cmd(C_WRW, 6'h3C);
        do_cmd(C_REC, 6'h00);
        chk("R10", "recall while busy rejected", reject_o, 1);
        chk("R4", "cell not yet written", rd_nv_o, 6'h15);
        wait_idle(len);
        chk("R10", "save window length kept", len + 2, T_PROG);
        chk("R4", "cell holds captured position", rd_nv_o, 6'h09);
        chk("R10", "wiper not recalled", wiper_o, 6'h3C);

        // Set position during a recall window is dropped.
        do_cmd(C_REC, 6'h00);
        do_cmd(C_WRW, 6'h01);
        chk("R10", "set position during recall rejected", reject_o, 1);
        wait_idle(len);
        chk("R5", "recall result", wiper_o, 6'h09);

        // Tick gating.
        tick_slow = 1'b1;
        @(negedge clk);
        do_cmd(C_WRNV, 6'h2E);
        wait_idle(len);
        chk("R12", "slow tick window in range",
            int'(len >= 2 * T_PROG - 1 && len <= 2 * T_PROG), 1);
        chk("R12", "slow tick cell value", rd_nv_o, 6'h2E);
        tick_slow = 1'b0;
        @(negedge clk);

        // Blank power-up, then recall from the blank cell.
        rst_ni = 1'b0;
        blank_ni = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_ni = 1'b1;
        blank_ni = 1'b1;
        wait_idle(len);
        chk("R11", "blank cell after erase", rd_nv_o, 6'h20);
        do_cmd(C_WRW, 6'h01);
        chk("R3", "position set", wiper_o, 6'h01);
        do_cmd(C_REC, 6'h00);
        wait_idle(len);
        chk("R11", "recall from blank cell", wiper_o, 6'h20);

        finish_run();
    end

endmodule